// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets clocked logic use an external asynchronous static RAM of 32768 nine-bit words. A host issues requests on a valid/ready channel: each request carries a write flag, a 15-bit word address and, for writes, nine bits of data. The sequencer turns every request into a timed sequence on the memory pins: two chip selects of opposite polarity, an active-low output enable, an active-low write enable, the address bus, and a data bus with separate outgoing and incoming halves plus a drive-enable for the outgoing half.

Every timing interval is a count of system clocks taken from plain configuration inputs. These are address-to-data time, output-enable-to-data time, write data setup, write pulse width and the turnaround after a write. A count of zero is treated as one. Reads return data on a second valid/ready channel. The host may hold off a response by keeping `rsp_ready` low. The response then stays valid and unchanged, and no new request is accepted until it is taken. `req_ready` is high only while the sequencer is idle with no response pending. A request is taken on a rising edge where `req_valid` and `req_ready` are both high.

All memory pins come straight from flip-flops, so they change only on rising clock edges. The chip stays selected between reads, so back-to-back reads change only the address. After a write the chip is deselected.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, with no request taken: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: The chip counts as selected only when `mem_cs_n`=0 and `mem_cs`=1. It is selected whenever `mem_oe_n` or `mem_we_n` is low. Once a write finishes and the sequencer is idle, it is deselected.
- R3: A read holds `mem_oe_n` low, with `mem_we_n` high and `mem_dq_oe` low, for exactly N = max(`cfg_addr_acc`, `cfg_oe_acc`, 1) clocks. The last of those edges samples `mem_dq_i`, and that value is the response data.
- R4: When a read is accepted on edge k and the previous access was not a write, `rsp_valid` rises after edge k+1+N. When the previous access was a write, it rises after edge k+1+T+N, with T = max(`cfg_turn`, 1).
- R5: `mem_dq_oe` and a low `mem_oe_n` are never active together. `mem_dq_oe` is already low in the clock before `mem_oe_n` falls.
- R6: A write drives `mem_dq_oe` high with `mem_we_n` high for max(`cfg_wr_setup`, 1) clocks. It then holds `mem_we_n` low for max(`cfg_wr_pulse`, 1) clocks with `mem_oe_n` high throughout. It returns to idle (`req_ready`=1) after edge k+S+P+1 when accepted on edge k.
- R7: `mem_addr` and `mem_dq_o` stay unchanged, and `mem_dq_oe` stays high, from the fall of `mem_we_n` through the clock after its rise.
- R8: A read following a write leaves the data bus undriven by both sides for at least T+1 clocks before `mem_oe_n` falls.
- R9: Between two reads with no write in between, the chip stays selected while the sequencer is idle.
- R10: A response with `rsp_ready` low keeps `rsp_valid` high and `rsp_data` unchanged, and `req_ready` stays low until the response is taken.
- R11: A read returns the data of the most recent write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr_acc | input | 4 | Address-to-data time in clocks |
| cfg_oe_acc | input | 4 | Output-enable-to-data time in clocks |
| cfg_wr_setup | input | 4 | Write data setup before write enable, clocks |
| cfg_wr_pulse | input | 4 | Write enable low width, clocks |
| cfg_turn | input | 4 | Idle bus clocks before a read that follows a write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 9 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 9 | Read data |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 9 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 9 | Data from the memory |

## Verification
Read responses are due 1+N edges after acceptance, or 1+T+N after a write. A write releases `req_ready` S+P+1 edges after acceptance. The driver changes inputs one time unit after a rising edge and counts edges until the result shows, comparing that count with the value worked out from the configuration. Pin-level intervals are counted at falling edges from the pin transitions themselves, which are one edge apart: output-enable low width, write setup and pulse width, and bus idle time before a read. The memory model drives stale data outside an active read, so a mis-timed sample is caught by the scoreboard.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RREL,
    ST_RACC,
    ST_RESP,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } seq_st_e;
endpackage

// File: rtl/sram_cnt.sv
module sram_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= ld_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - {{(CW-1){1'b0}}, 1'b1};
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_rsp_hold.sv
module sram_rsp_hold #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cap) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cap_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: an unaccepted response must stay put
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_seq_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 9,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_addr_acc,
  input  logic [CW-1:0] cfg_oe_acc,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_pulse,
  input  logic [CW-1:0] cfg_turn,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          rsp_pend,
  input  logic          rsp_ready,
  output logic          cap,
  output logic          sel_q,
  output logic          oe_n_q,
  output logic          we_n_q,
  output logic          dq_oe_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wd_q
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  seq_st_e       st_q, st_nx;
  logic          ld, done, accept, last_wr_q, sel_nx;
  logic [CW-1:0] ldv, rd_len;

  function automatic logic [CW-1:0] len_m1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  assign rd_len    = (cfg_addr_acc > cfg_oe_acc) ? cfg_addr_acc : cfg_oe_acc;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  sram_cnt #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld),
    .ld_val (ldv),
    .done   (done)
  );

  always_comb begin
    st_nx = st_q;
    ld    = 1'b0;
    ldv   = '0;
    cap   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_we) begin
          st_nx = ST_WSET; ld = 1'b1; ldv = len_m1(cfg_wr_setup);
        end else if (last_wr_q) begin
          st_nx = ST_TURN; ld = 1'b1; ldv = len_m1(cfg_turn);
        end else begin
          st_nx = ST_RREL;
        end
      end
      ST_TURN: if (done) st_nx = ST_RREL;
      ST_RREL: begin
        st_nx = ST_RACC; ld = 1'b1; ldv = len_m1(rd_len);
      end
      ST_RACC: if (done) begin
        st_nx = ST_RESP; cap = 1'b1;
      end
      ST_RESP: if (rsp_pend && rsp_ready) st_nx = ST_IDLE;
      ST_WSET: if (done) begin
        st_nx = ST_WPUL; ld = 1'b1; ldv = len_m1(cfg_wr_pulse);
      end
      ST_WPUL: if (done) st_nx = ST_WHLD;
      ST_WHLD: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  // chip select follows the state being entered; idle keeps it after reads only
  always_comb begin
    case (st_nx)
      ST_IDLE: begin
        if (st_q == ST_RESP)      sel_nx = 1'b1;
        else if (st_q == ST_WHLD) sel_nx = 1'b0;
        else                      sel_nx = sel_q;
      end
      ST_TURN: sel_nx = 1'b0;
      default: sel_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_wr_q <= 1'b0;
      sel_q     <= 1'b0;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
    end else begin
      st_q    <= st_nx;
      sel_q   <= sel_nx;
      oe_n_q  <= (st_nx != ST_RACC);
      we_n_q  <= (st_nx != ST_WPUL);
      dq_oe_q <= (st_nx == ST_WSET) || (st_nx == ST_WPUL) || (st_nx == ST_WHLD);
      if (accept) begin
        addr_q    <= req_addr;
        last_wr_q <= req_we;
        if (req_we) wd_q <= req_wdata;
      end
    end
  end

  // R5: our driver and the memory's outputs never overlap
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> oe_n_q);
  // R5: driver already off one clock before output enable falls
  p_release_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n_q) |-> !$past(dq_oe_q));
  // R6: output enable stays high while write enable is low
  p_we_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (oe_n_q && dq_oe_q));
  // R7: address and data hold through the pulse and one clock after
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |=> ($stable(addr_q) && $stable(wd_q) && dq_oe_q));
  // R2: any strobe implies the chip is selected
  p_sel_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_q || !we_n_q) |-> sel_q);
  // R10: no new request while a response waits
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_pend);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int AW = 15,
  parameter int DW = 9,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_addr_acc,
  input  logic [CW-1:0] cfg_oe_acc,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_pulse,
  input  logic [CW-1:0] cfg_turn,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  logic cap, sel;

  sram_ctl_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_addr_acc (cfg_addr_acc),
    .cfg_oe_acc   (cfg_oe_acc),
    .cfg_wr_setup (cfg_wr_setup),
    .cfg_wr_pulse (cfg_wr_pulse),
    .cfg_turn     (cfg_turn),
    .req_valid    (req_valid),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .rsp_pend     (rsp_valid),
    .rsp_ready    (rsp_ready),
    .cap          (cap),
    .sel_q        (sel),
    .oe_n_q       (mem_oe_n),
    .we_n_q       (mem_we_n),
    .dq_oe_q      (mem_dq_oe),
    .addr_q       (mem_addr),
    .wd_q         (mem_dq_o)
  );

  sram_rsp_hold #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap),
    .cap_data  (mem_dq_i),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign mem_cs_n = ~sel;
  assign mem_cs   = sel;
endmodule

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int WD    = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_addr_acc = 4'd3, cfg_oe_acc = 4'd2, cfg_wr_setup = 4'd2;
  logic [3:0] cfg_wr_pulse = 4'd3, cfg_turn = 4'd2;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [14:0] req_addr = '0;
  logic [8:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [8:0]  rsp_data;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [8:0]  mem_dq_o, mem_dq_i;

  int checks = 0, errors = 0;
  int exp_n, exp_s, exp_p, exp_t;
  logic [8:0] mem_m [0:255];
  logic [8:0] exp_mem [int];
  logic [8:0] exp_q [$];
  bit prev_rd = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_acc(cfg_addr_acc), .cfg_oe_acc(cfg_oe_acc), .cfg_wr_setup(cfg_wr_setup),
    .cfg_wr_pulse(cfg_wr_pulse), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model: real data only in a proper read, stale pattern otherwise
  assign mem_dq_i = (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n && !mem_dq_oe)
                    ? mem_m[mem_addr[7:0]] : 9'h1AA;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int a, input int o, input int s, input int p, input int t);
    cfg_addr_acc = 4'(a); cfg_oe_acc = 4'(o); cfg_wr_setup = 4'(s);
    cfg_wr_pulse = 4'(p); cfg_turn = 4'(t);
    exp_n = (a > o) ? a : o;
    if (exp_n < 1) exp_n = 1;
    exp_s = (s < 1) ? 1 : s;
    exp_p = (p < 1) ? 1 : p;
    exp_t = (t < 1) ? 1 : t;
  endtask

  task automatic do_write(input logic [14:0] a, input logic [8:0] d);
    int n;
    while (!req_ready) tick();
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    tick();
    req_valid = 1'b0;
    exp_mem[int'(a)] = d;
    n = 0;
    chk(!req_ready, "R10 ready low while busy", int'(req_ready), 0);
    while (!req_ready && n < 100) begin tick(); n++; end
    chk(n == exp_s + exp_p + 1, "R6 write duration", n, exp_s + exp_p + 1);
    chk(mem_cs_n && !mem_cs && !mem_dq_oe, "R2 deselected after write",
        int'({mem_cs_n, mem_cs, mem_dq_oe}), 4);
    prev_rd = 0;
  endtask

  task automatic do_read(input logic [14:0] a, input bit bp);
    int n, lat;
    logic [8:0] held;
    bit after_wr;
    while (!req_ready) tick();
    if (prev_rd)
      chk(!mem_cs_n && mem_cs, "R9 kept selected between reads",
          int'({mem_cs_n, mem_cs}), 1);
    after_wr = !prev_rd;
    if (bp) rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    tick();
    req_valid = 1'b0;
    exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 9'h000);
    n = 0;
    while (!rsp_valid && n < 100) begin tick(); n++; end
    lat = after_wr ? (1 + exp_t + exp_n) : (1 + exp_n);
    chk(n == lat, "R4 read latency", n, lat);
    if (bp) begin
      held = rsp_data;
      for (int i = 0; i < 3; i++) begin
        tick();
        chk(rsp_valid && rsp_data == held && !req_ready, "R10 response held",
            int'(rsp_data), int'(held));
      end
      rsp_ready = 1'b1;
    end
    tick();
    prev_rd = 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected response", int'(rsp_data), -1);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(rsp_data == e, "R3/R11 read data", int'(rsp_data), int'(e));
      end
    end
  end

  // pin-level timing monitor
  logic        p_oe_n = 1, p_we_n = 1, p_dq_oe = 0;
  int          oe_cnt = 0, we_cnt = 0, ws_cnt = 0, idle_gap = 0;
  bit          wr_seen = 0;
  logic [14:0] ws_addr;
  logic [8:0]  ws_dat;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(mem_dq_oe && !mem_oe_n) && !(!mem_we_n && !mem_oe_n), "R5 no overlap",
          int'({mem_dq_oe, mem_oe_n, mem_we_n}), 0);
      if (p_oe_n && !mem_oe_n) begin
        chk(!p_dq_oe && !mem_dq_oe, "R5 released before oe", int'(p_dq_oe), 0);
        chk(!mem_cs_n && mem_cs && mem_we_n, "R2 read selected", int'(mem_cs), 1);
        if (wr_seen) chk(idle_gap >= exp_t + 1, "R8 turnaround", idle_gap, exp_t + 1);
      end
      if (!p_oe_n && mem_oe_n) begin
        chk(oe_cnt == exp_n, "R3 oe low width", oe_cnt, exp_n);
        wr_seen = 0;
      end
      if (p_we_n && !mem_we_n)
        chk(ws_cnt == exp_s, "R6 data setup", ws_cnt, exp_s);
      if (!p_we_n)
        chk(mem_addr == ws_addr && mem_dq_o == ws_dat && mem_dq_oe, "R7 hold",
            int'(mem_addr), int'(ws_addr));
      if (!mem_we_n)
        chk(mem_oe_n && !mem_cs_n && mem_cs, "R6 oe high in write", int'(mem_oe_n), 1);
      if (!p_we_n && mem_we_n) begin
        chk(we_cnt == exp_p, "R6 pulse width", we_cnt, exp_p);
        mem_m[mem_addr[7:0]] = mem_dq_o;
        wr_seen = 1;
      end
      if (p_we_n && !mem_we_n) begin ws_addr = mem_addr; ws_dat = mem_dq_o; end
      oe_cnt   = mem_oe_n ? 0 : oe_cnt + 1;
      we_cnt   = mem_we_n ? 0 : we_cnt + 1;
      ws_cnt   = !mem_dq_oe ? 0 : (mem_we_n ? ws_cnt + 1 : ws_cnt);
      idle_gap = mem_dq_oe ? 0 : idle_gap + 1;
      p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 9'h000;
    set_cfg(3, 2, 2, 3, 2);
    repeat (3) tick();
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 pins in reset", int'({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}), 22);
    rst_n = 1'b1;
    tick();
    chk(req_ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 idle after reset", int'(req_ready), 1);

    do_write(15'h0000, 9'h1A5);
    do_write(15'h7FFF, 9'h0FF);
    do_write(15'h0123, 9'h05A);
    do_read(15'h0000, 0);
    do_read(15'h7FFF, 0);
    do_read(15'h0123, 1);

    set_cfg(0, 0, 0, 0, 0);
    do_write(15'h4C56, 9'h133);
    do_read(15'h4C56, 0);
    do_read(15'h0000, 0);

    set_cfg(1, 5, 4, 2, 3);
    do_read(15'h7FFF, 0);
    do_write(15'h0000, 9'h0C3);
    do_read(15'h0000, 0);
    do_read(15'h0123, 0);

    repeat (4) tick();
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule